// File: doc/BRIEF.md
# Key-Adjusted PWM Duty Generator

This block drives a motor power stage with a fixed-frequency pulse-width-modulated signal. Its duty cycle is set by four active-low push keys. A prescaler turns the system clock into a slower enable tick. With the default settings it divides 27 MHz down to a 1 MHz tick. A two-level period counter, running on that tick, builds a 10000-tick period, which gives a 100 Hz output. The output is high at the start of each period for a share of the period that follows the duty value.

The duty is held in tenths of a percent, from 0 to 999, so the highest setting is 99.9%. Each key input is synchronised and then debounced. An accepted press steps the duty once. While the key stays down, the duty keeps stepping after a hold delay and then at a steady repeat rate. The setpoint is exported for a numeric display.

A new setpoint reaches the comparator only at a period boundary, so the output never shows a cut-short or stray pulse.

Top module: `pwm_key_duty`

## Requirements
- R1: After reset, `dutyValue` is 0 and `pwmOut` is low.
- R2: `pwmOut` repeats every `PWM_SCALE*(DUTY_MAX+1)` ticks, and one tick occurs every `CLK_DIV` clocks. It is high for the first `applied duty * PWM_SCALE` ticks of each period. With the defaults (27, 10, 999) this is a 100 Hz output from a 27 MHz clock.
- R3: The setpoint never exceeds `DUTY_MAX` (999, which is 99.9%) and never goes below 0. A step that would pass either limit stops at the limit.
- R4: Each key bit is active-low and has its own step. `keyN[0]` adds `FINE_STEP` (1), `keyN[1]` subtracts `FINE_STEP`, `keyN[2]` adds `COARSE_STEP` (10) and `keyN[3]` subtracts `COARSE_STEP`. When several keys step in the same cycle, their steps are summed and the limits are applied once to the total.
- R5: A key level is accepted only after it has stayed unchanged for `DEB_TICKS` ticks. A pulse shorter than that changes nothing.
- R6: An accepted press steps the setpoint exactly once. An accepted release does not step it.
- R7: While an accepted press continues, further steps occur `REP_DELAY` ticks after the press, and then every `REP_RATE` ticks until the key is released.
- R8: A changed setpoint takes effect only at the start of the next PWM period. The period in progress keeps its width.
- R9: `dutyValue` shows the setpoint, and it updates in the clock cycle after a step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (27 MHz by default) |
| rstN | input | 1 | Asynchronous active-low reset |
| keyN | input | 4 | Active-low push keys: +fine, -fine, +coarse, -coarse |
| pwmOut | output | 1 | PWM drive to the power stage |
| dutyValue | output | $clog2(DUTY_MAX+1) | Duty setpoint in tenths of a percent, for the display |

## Verification
A key change reaches `dutyValue` about 2 synchronizer cycles, plus `DEB_TICKS` ticks, plus 2 register cycles after the edge. The bench therefore holds each key and each release well beyond that time before it reads `dutyValue` on a falling clock edge. The bench shrinks the hold-repeat windows, and it chooses hold lengths that fall halfway between two repeat instants, so a tick's worth of phase uncertainty cannot change the expected step count. The PWM width is checked in three ways:
- counting high samples over a full 2000-cycle period window, two periods after the setpoint last changed;
- timing a single pulse from its rising edge;
- timing from one rising edge to the next.

Pulses are timed in the period before and the period after a mid-period change.

// File: rtl/pwm_key_pkg.sv
package pwm_key_pkg;

  localparam int NUM_KEYS = 4;

  // Bit position of each key inside keyN
  localparam int KEY_INC_FINE   = 0;
  localparam int KEY_DEC_FINE   = 1;
  localparam int KEY_INC_COARSE = 2;
  localparam int KEY_DEC_COARSE = 3;

  // Step strobes from control to datapath, one cycle each
  typedef struct packed {
    logic decCoarse;
    logic incCoarse;
    logic decFine;
    logic incFine;
  } stepStrobe_t;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int CLK_DIV = 27
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int TW = $clog2(CLK_DIV + 1);

  logic [TW-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (divCnt == TW'(CLK_DIV - 1)) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign tick = (divCnt == TW'(CLK_DIV - 1));
endmodule

// File: rtl/pwm_key_ctrl.sv
module pwm_key_ctrl
  import pwm_key_pkg::*;
#(
  parameter int DEB_TICKS = 20000,
  parameter int REP_DELAY = 500000,
  parameter int REP_RATE  = 100000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [NUM_KEYS-1:0] keyN,
  output stepStrobe_t         steps
);
  localparam int DBW   = $clog2(DEB_TICKS + 1);
  localparam int HOLDM = (REP_DELAY > REP_RATE) ? REP_DELAY : REP_RATE;
  localparam int HW    = $clog2(HOLDM + 1);

  logic [NUM_KEYS-1:0] fireVec;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    logic [1:0]     syncQ;
    logic           rawPressed;
    logic           stableLvl;
    logic           stableQ;
    logic           pressEdge;
    logic [DBW-1:0] debCnt;
    logic [HW-1:0]  holdCnt;
    logic           repeating;
    logic           fire;

    // Two-flop synchronizer, inverted so 1 means pressed
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
      end else begin
        syncQ <= {syncQ[0], ~keyN[k]};
      end
    end
    assign rawPressed = syncQ[1];

    // Debounce: the new level must hold for DEB_TICKS ticks
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stableLvl <= 1'b0;
        debCnt    <= '0;
      end else if (rawPressed == stableLvl) begin
        debCnt <= '0;
      end else if (tick) begin
        if (debCnt == DBW'(DEB_TICKS - 1)) begin
          stableLvl <= rawPressed;
          debCnt    <= '0;
        end else begin
          debCnt <= debCnt + 1'b1;
        end
      end
    end

    assign pressEdge = stableLvl & ~stableQ;

    // First step on press, then hold delay, then repeat rate
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stableQ   <= 1'b0;
        holdCnt   <= '0;
        repeating <= 1'b0;
        fire      <= 1'b0;
      end else begin
        stableQ <= stableLvl;
        fire    <= 1'b0;
        if (pressEdge) begin
          fire      <= 1'b1;
          holdCnt   <= '0;
          repeating <= 1'b0;
        end else if (!stableLvl) begin
          holdCnt   <= '0;
          repeating <= 1'b0;
        end else if (tick) begin
          if (!repeating && holdCnt == HW'(REP_DELAY - 1)) begin
            fire      <= 1'b1;
            repeating <= 1'b1;
            holdCnt   <= '0;
          end else if (repeating && holdCnt == HW'(REP_RATE - 1)) begin
            fire    <= 1'b1;
            holdCnt <= '0;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
      end
    end

    assign fireVec[k] = fire;
  end

  assign steps.incFine   = fireVec[KEY_INC_FINE];
  assign steps.decFine   = fireVec[KEY_DEC_FINE];
  assign steps.incCoarse = fireVec[KEY_INC_COARSE];
  assign steps.decCoarse = fireVec[KEY_DEC_COARSE];
endmodule

// File: rtl/pwm_duty_path.sv
module pwm_duty_path
  import pwm_key_pkg::*;
#(
  parameter int DUTY_MAX    = 999,
  parameter int PWM_SCALE   = 10,
  parameter int FINE_STEP   = 1,
  parameter int COARSE_STEP = 10,
  localparam int DW = $clog2(DUTY_MAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  stepStrobe_t   steps,
  output logic [DW-1:0] dutySet,
  output logic [DW-1:0] dutyAct,
  output logic          wrap,
  output logic          pwmOut
);
  localparam int FW = $clog2(PWM_SCALE + 1);

  logic [FW-1:0] fineCnt;
  logic [DW-1:0] coarseCnt;
  logic          fineEnd;
  int            sumDuty;
  int            clampDuty;

  // Sum all strobed steps, then apply the limits once
  always_comb begin
    sumDuty = int'(dutySet);
    if (steps.incFine)   sumDuty = sumDuty + FINE_STEP;
    if (steps.decFine)   sumDuty = sumDuty - FINE_STEP;
    if (steps.incCoarse) sumDuty = sumDuty + COARSE_STEP;
    if (steps.decCoarse) sumDuty = sumDuty - COARSE_STEP;
    if (sumDuty < 0) begin
      clampDuty = 0;
    end else if (sumDuty > DUTY_MAX) begin
      clampDuty = DUTY_MAX;
    end else begin
      clampDuty = sumDuty;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutySet <= '0;
    end else if (|steps) begin
      dutySet <= DW'(clampDuty);
    end
  end

  // Period counter: PWM_SCALE fine ticks per step, DUTY_MAX+1 steps
  assign fineEnd = (fineCnt == FW'(PWM_SCALE - 1));
  assign wrap    = tick && fineEnd && (coarseCnt == DW'(DUTY_MAX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fineCnt   <= '0;
      coarseCnt <= '0;
    end else if (tick) begin
      if (fineEnd) begin
        fineCnt   <= '0;
        coarseCnt <= wrap ? '0 : coarseCnt + 1'b1;
      end else begin
        fineCnt <= fineCnt + 1'b1;
      end
    end
  end

  // Applied duty changes only at the period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyAct <= '0;
    end else if (wrap) begin
      dutyAct <= dutySet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmOut <= 1'b0;
    end else begin
      pwmOut <= (coarseCnt < dutyAct);
    end
  end
endmodule

// File: rtl/pwm_key_duty.sv
module pwm_key_duty
  import pwm_key_pkg::*;
#(
  parameter int CLK_DIV     = 27,
  parameter int PWM_SCALE   = 10,
  parameter int DUTY_MAX    = 999,
  parameter int DEB_TICKS   = 20000,
  parameter int REP_DELAY   = 500000,
  parameter int REP_RATE    = 100000,
  parameter int FINE_STEP   = 1,
  parameter int COARSE_STEP = 10,
  localparam int DW = $clog2(DUTY_MAX + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_KEYS-1:0] keyN,
  output logic                pwmOut,
  output logic [DW-1:0]       dutyValue
);
  logic          tick;
  stepStrobe_t   steps;
  logic [DW-1:0] dutyAct;
  logic          wrap;

  pwm_tick_gen #(.CLK_DIV(CLK_DIV)) tick_i (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  pwm_key_ctrl #(
    .DEB_TICKS (DEB_TICKS),
    .REP_DELAY (REP_DELAY),
    .REP_RATE  (REP_RATE)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (tick),
    .keyN  (keyN),
    .steps (steps)
  );

  pwm_duty_path #(
    .DUTY_MAX    (DUTY_MAX),
    .PWM_SCALE   (PWM_SCALE),
    .FINE_STEP   (FINE_STEP),
    .COARSE_STEP (COARSE_STEP)
  ) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .steps   (steps),
    .dutySet (dutyValue),
    .dutyAct (dutyAct),
    .wrap    (wrap),
    .pwmOut  (pwmOut)
  );
endmodule

// File: rtl/pwm_key_duty_chk.sv
module pwm_key_duty_chk
  import pwm_key_pkg::*;
#(
  parameter int DUTY_MAX    = 999,
  parameter int FINE_STEP   = 1,
  parameter int COARSE_STEP = 10,
  localparam int DW = $clog2(DUTY_MAX + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [DW-1:0] dutyValue,
  input logic [DW-1:0] dutyAct,
  input logic          wrap,
  input logic          pwmOut,
  input stepStrobe_t   steps
);
  AST_DUTY_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    dutyValue <= DW'(DUTY_MAX)); // R3

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (|steps) |=> ((int'(dutyValue) - int'($past(dutyValue)) <= FINE_STEP + COARSE_STEP) &&
                  (int'($past(dutyValue)) - int'(dutyValue) <= FINE_STEP + COARSE_STEP))); // R4

  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (steps == '0) |=> $stable(dutyValue)); // R6

  AST_APPLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dutyAct) |-> $past(wrap)); // R8

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (dutyAct == '0) |=> !pwmOut); // R2
endmodule

bind pwm_key_duty pwm_key_duty_chk #(
  .DUTY_MAX    (DUTY_MAX),
  .FINE_STEP   (FINE_STEP),
  .COARSE_STEP (COARSE_STEP)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .dutyValue (dutyValue),
  .dutyAct   (dutyAct),
  .wrap      (wrap),
  .pwmOut    (pwmOut),
  .steps     (steps)
);

// File: tb/pwm_key_duty_tb_top.sv
`timescale 1ns/1ps
module pwm_key_duty_tb_top;
  localparam int CLK_DIV   = 2;
  localparam int PWM_SCALE = 1;
  localparam int DUTY_MAX  = 999;
  localparam int PERIOD_CY = CLK_DIV * PWM_SCALE * (DUTY_MAX + 1);
  localparam int DW        = $clog2(DUTY_MAX + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    keyN = 4'hF;
  logic          pwmOut;
  logic [DW-1:0] dutyValue;
  int            checks = 0;
  int            errors = 0;
  bit            finished = 1'b0;

  always #2 clk = ~clk;

  pwm_key_duty #(
    .CLK_DIV   (CLK_DIV),
    .PWM_SCALE (PWM_SCALE),
    .DUTY_MAX  (DUTY_MAX),
    .DEB_TICKS (4),
    .REP_DELAY (40),
    .REP_RATE  (10)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .keyN      (keyN),
    .pwmOut    (pwmOut),
    .dutyValue (dutyValue)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(input int mask, input int holdCy);
    @(negedge clk);
    keyN = ~4'(mask);
    repeat (holdCy) @(negedge clk);
    keyN = 4'hF;
    repeat (40) @(negedge clk);
  endtask

  task automatic countHigh(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut) n++;
    end
  endtask

  task automatic waitRise();
    @(negedge clk);
    while (pwmOut) @(negedge clk);
    while (!pwmOut) @(negedge clk);
  endtask

  task automatic measurePeriodHigh(output int n);
    repeat (2 * PERIOD_CY) @(negedge clk);
    countHigh(PERIOD_CY, n);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 duty", int'(dutyValue), 0);
    check("R1 pwm", int'(pwmOut), 0);
  endtask

  task automatic t_single_keys();
    // R9: setpoint shows while the key is still held
    @(negedge clk);
    keyN = ~4'b0100;
    repeat (30) @(negedge clk);
    check("R9 coarse up visible while held", int'(dutyValue), 10);
    keyN = 4'hF;
    repeat (40) @(negedge clk);
    check("R6 release gives no step", int'(dutyValue), 10);
    press(4'b0001, 30);
    check("R4 fine up", int'(dutyValue), 11);
    press(4'b0010, 30);
    check("R4 fine down", int'(dutyValue), 10);
    press(4'b1000, 30);
    check("R4 coarse down", int'(dutyValue), 0);
  endtask

  task automatic t_bounce();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      keyN = 4'b1110;
      repeat (3) @(negedge clk);
      keyN = 4'hF;
      repeat (3) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    check("R5 short pulses ignored", int'(dutyValue), 0);
  endtask

  task automatic t_pwm_width();
    int n;
    int gap;
    press(4'b0100, 30);
    measurePeriodHigh(n);
    check("R2 high count duty 10", n, 10 * CLK_DIV * PWM_SCALE);
    waitRise();
    gap = 1;
    @(negedge clk);
    while (pwmOut) begin gap++; @(negedge clk); end
    while (!pwmOut) begin gap++; @(negedge clk); end
    check("R2 period length", gap, PERIOD_CY);
  endtask

  task automatic t_boundary_apply();
    int n;
    int w;
    // Align to the falling edge of the duty-10 pulse
    waitRise();
    while (pwmOut) @(negedge clk);
    press(4'b0100, 30);
    check("R9 duty after mid-period step", int'(dutyValue), 20);
    countHigh(1800, n);
    check("R8 no pulse before boundary", n, 0);
    waitRise();
    w = 1;
    @(negedge clk);
    while (pwmOut) begin w++; @(negedge clk); end
    check("R8 new width from next period", w, 20 * CLK_DIV * PWM_SCALE);
  endtask

  task automatic t_hold_repeat();
    // First step, then repeats at 80,100,120,140,160 cycles within a 170-cycle hold
    press(4'b0001, 170);
    check("R7 hold repeat count", int'(dutyValue), 26);
  endtask

  task automatic t_simultaneous();
    press(4'b0101, 30);
    check("R4 summed steps", int'(dutyValue), 37);
  endtask

  task automatic t_limits();
    int n;
    press(4'b0100, 2400);
    check("R3 clamp at ceiling", int'(dutyValue), 999);
    press(4'b0001, 30);
    check("R3 no step past ceiling", int'(dutyValue), 999);
    press(4'b0010, 30);
    press(4'b0010, 30);
    press(4'b0010, 30);
    press(4'b0010, 30);
    check("R4 down to 995", int'(dutyValue), 995);
    press(4'b0100, 30);
    check("R3 coarse step clamped", int'(dutyValue), 999);
    measurePeriodHigh(n);
    check("R2 high count at 99.9 percent", n, 999 * CLK_DIV * PWM_SCALE);
    press(4'b1000, 2400);
    check("R3 clamp at floor", int'(dutyValue), 0);
    press(4'b0010, 30);
    check("R3 no step below floor", int'(dutyValue), 0);
    measurePeriodHigh(n);
    check("R2 zero duty stays low", n, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_single_keys();
    t_bounce();
    t_pwm_width();
    t_boundary_apply();
    t_hold_repeat();
    t_simultaneous();
    t_limits();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule